// File: doc/BRIEF.md
# Shift-Loaded Cascaded Address Counter

This block produces the address for a byte-wide static RAM whose data pins share one 8-bit bus with the address source. The address is kept in a chain of byte-wide counter stages, by default two, giving a 16-bit address over 64 KB. Every stage sees the same clock, the same active-low load line and the same count enable. Because there is no separate load path per stage, a load shifts the chain by one byte. The bus byte goes into the lowest stage and each stage passes its old value one place up. A full address is therefore written by presenting the high byte on one load clock and the low byte on the next.

With load released, the chain behaves as a cascaded binary counter. When count enable is high, the address steps up by one on each clock. The carry from a saturated stage advances the stage above it, and the address wraps from all ones to zero. The block also splits a single active-low memory strobe into the RAM's output-enable and write-enable, using the load line to choose between them, and holds the RAM's chip select permanently active. To read a run of bytes, the host releases load and pulses the strobe, stepping the count between bytes. To write, the host pulses the strobe while load is held low.

Top module: `shift_addr_counter`

## Requirements
- R1: A synchronous active-high reset `rst` clears the whole address to 0x0000 on the next rising clock.
- R2: On a rising clock with `load_n` low, the low byte `addr[7:0]` takes `bus_in` and the high byte `addr[15:8]` takes the previous low byte, both on the same edge.
- R3: Two consecutive load clocks, with the high byte presented first and the low byte second, leave the full 16-bit address equal to {first byte, second byte}.
- R4: On a rising clock with `load_n` high and `cnt_en` high, the address increases by one. When the low byte is 0xFF, it becomes 0x00 and the high byte increases by one.
- R5: Incrementing from 0xFFFF gives 0x0000.
- R6: On a rising clock with `load_n` high and `cnt_en` low, the address does not change.
- R7: A load with `load_n` low happens whatever the value of `cnt_en`.
- R8: `ram_oe_n` is low exactly when `strobe_n` is low and `load_n` is high.
- R9: `ram_we_n` is low exactly when `strobe_n` is low and `load_n` is low, so the two enables are never low together.
- R10: `ram_cs_n` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all counter stages |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low shift-load control, common to all stages |
| cnt_en | input | 1 | Count enable for the chain |
| bus_in | input | 8 | Byte from the shared address/data bus |
| strobe_n | input | 1 | Combined active-low memory strobe |
| addr | output | 16 | Address to the RAM |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_cs_n | output | 1 | RAM chip select, held active (0) |

## Verification
On every cycle, the assertions check the per-stage step rules: a load copies the stage below (or the bus), a count adds one, and an idle stage holds. They also check the whole-address increment, the wrap to zero when the top carry is set, and that the two RAM enables are never low together. The bench scenarios cover what no single-cycle property can show. These are the two-clock ordering that builds a full address from high-then-low bytes, a carry crossing the byte boundary, the hold when the enable is low, a load with the enable low, and the address after a reset in the middle of counting. They also include every combination of strobe and load driving the enables, and chip select staying at zero.

// File: rtl/addr_chain_pkg.sv
package addr_chain_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_STAGES = 2;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } stage_op_e;

    typedef struct packed {
        logic oe_n;
        logic we_n;
    } ram_ctl_t;

    function automatic stage_op_e pick_op(input logic load_n, input logic carry_in);
        if (!load_n)
            return OP_LOAD;
        else if (carry_in)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction
endpackage

// File: rtl/addr_byte_stage.sv
module addr_byte_stage
    import addr_chain_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         carry_in,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q,
    output logic         carry_out
);
    localparam logic [W-1:0] ONE = W'(1);

    stage_op_e op;

    always_comb op = pick_op(load_n, carry_in);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else begin
            case (op)
                OP_LOAD:  q <= load_val;
                OP_COUNT: q <= q + ONE;
                default:  q <= q;
            endcase
        end
    end

    assign carry_out = carry_in & (&q);

    // R2: a load copies the byte offered below (bus or lower stage)
    assert_stage_load_R2: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> q == $past(load_val));

    // R4: a counting stage advances by one
    assert_stage_step_R4: assert property (@(posedge clk) disable iff (rst)
        (load_n && carry_in) |=> q == $past(q) + ONE);

    // R6: without carry-in and without load the stage holds
    assert_stage_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (load_n && !carry_in) |=> $stable(q));
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import addr_chain_pkg::*;
(
    input  logic     strobe_n,
    input  logic     load_n,
    output ram_ctl_t ctl
);
    always_comb begin
        ctl.oe_n = ~(~strobe_n &  load_n);
        ctl.we_n = ~(~strobe_n & ~load_n);
    end
endmodule

// File: rtl/shift_addr_counter.sv
module shift_addr_counter
    import addr_chain_pkg::*;
#(
    parameter int STAGE_W = BYTE_W,
    parameter int STAGES  = NUM_STAGES,
    localparam int ADDR_W = STAGE_W * STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              cnt_en,
    input  logic [STAGE_W-1:0] bus_in,
    input  logic              strobe_n,
    output logic [ADDR_W-1:0] addr,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic              ram_cs_n
);
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

    logic [STAGE_W-1:0] stage_q   [STAGES];
    logic               stage_cin [STAGES];
    logic               stage_cout[STAGES];
    ram_ctl_t           ctl;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            logic [STAGE_W-1:0] feed;
            if (i == 0) begin : g_first
                assign stage_cin[i] = cnt_en;
                assign feed         = bus_in;
            end else begin : g_upper
                assign stage_cin[i] = stage_cout[i-1];
                assign feed         = stage_q[i-1];
            end

            addr_byte_stage #(.W(STAGE_W)) u_stage (
                .clk       (clk),
                .rst       (rst),
                .load_n    (load_n),
                .carry_in  (stage_cin[i]),
                .load_val  (feed),
                .q         (stage_q[i]),
                .carry_out (stage_cout[i])
            );

            assign addr[i*STAGE_W +: STAGE_W] = stage_q[i];
        end
    endgenerate

    strobe_decode u_dec (
        .strobe_n (strobe_n),
        .load_n   (load_n),
        .ctl      (ctl)
    );

    assign ram_oe_n = ctl.oe_n;
    assign ram_we_n = ctl.we_n;
    assign ram_cs_n = 1'b0;

    // R4: whole-address increment across the byte boundary
    assert_addr_inc_R4: assert property (@(posedge clk) disable iff (rst)
        (load_n && cnt_en) |=> addr == $past(addr) + A_ONE);

    // R5: top carry while counting returns the address to zero
    assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (load_n && stage_cout[STAGES-1]) |=> addr == '0);

    // R9: output and write enables are never active together
    assert_enables_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(ram_oe_n == 1'b0 && ram_we_n == 1'b0));

    // R10: chip select stays active
    assert_cs_active_R10: assert property (@(posedge clk) disable iff (rst)
        ram_cs_n == 1'b0);
endmodule

// File: tb/tb_shift_addr_counter.sv
`timescale 1ns/1ps
module tb_shift_addr_counter;
    logic        clk = 1'b0;
    logic        rst;
    logic        load_n;
    logic        cnt_en;
    logic [7:0]  bus_in;
    logic        strobe_n;
    logic [15:0] addr;
    logic        ram_oe_n;
    logic        ram_we_n;
    logic        ram_cs_n;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    shift_addr_counter dut (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .bus_in   (bus_in),
        .strobe_n (strobe_n),
        .addr     (addr),
        .ram_oe_n (ram_oe_n),
        .ram_we_n (ram_we_n),
        .ram_cs_n (ram_cs_n)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at the falling edge, let one rising edge pass, sample 1 ns later
    task automatic step(input logic ld_n, input logic en, input logic [7:0] b);
        @(negedge clk);
        load_n = ld_n; cnt_en = en; bus_in = b;
        @(posedge clk);
        #1;
    endtask

    task automatic test_reset;
        @(negedge clk);
        rst = 1'b1; load_n = 1'b1; cnt_en = 1'b1; strobe_n = 1'b1; bus_in = 8'h00;
        @(posedge clk); #1;
        check(addr, 16'h0000, "R1 reset clears address");
        check({15'b0, ram_cs_n}, 16'h0000, "R10 chip select active");
        @(negedge clk); rst = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic test_load_shift;
        step(1'b0, 1'b0, 8'hAB);
        check(addr, 16'h00AB, "R2 first load shifts old low byte up");
        step(1'b0, 1'b0, 8'hCD);
        check(addr, 16'hABCD, "R3 high then low byte builds address");
        step(1'b0, 1'b0, 8'h5A);
        check(addr, 16'hCD5A, "R2 third load shifts again");
    endtask

    task automatic test_load_with_enable;
        step(1'b0, 1'b1, 8'h12);
        step(1'b0, 1'b1, 8'h34);
        check(addr, 16'h1234, "R7 load wins over count enable");
    endtask

    task automatic test_count_carry;
        step(1'b0, 1'b0, 8'h12);
        step(1'b0, 1'b0, 8'hFE);
        step(1'b1, 1'b1, 8'h77);
        check(addr, 16'h12FF, "R4 increment");
        step(1'b1, 1'b1, 8'h77);
        check(addr, 16'h1300, "R4 carry into high byte");
    endtask

    task automatic test_hold;
        step(1'b1, 1'b0, 8'h99);
        check(addr, 16'h1300, "R6 hold with enable low");
        step(1'b1, 1'b0, 8'h42);
        check(addr, 16'h1300, "R6 hold second cycle");
    endtask

    task automatic test_wrap;
        step(1'b0, 1'b0, 8'hFF);
        step(1'b0, 1'b0, 8'hFF);
        check(addr, 16'hFFFF, "R3 load all ones");
        step(1'b1, 1'b1, 8'h00);
        check(addr, 16'h0000, "R5 wrap to zero");
        step(1'b1, 1'b1, 8'h00);
        check(addr, 16'h0001, "R5 count after wrap");
    endtask

    task automatic test_strobe;
        @(negedge clk);
        cnt_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            strobe_n = k[0];
            load_n   = k[1];
            #1;
            check({15'b0, ram_oe_n}, {15'b0, ~(~k[0] & k[1])}, "R8 output enable decode");
            check({15'b0, ram_we_n}, {15'b0, ~(~k[0] & ~k[1])}, "R9 write enable decode");
            check({15'b0, ram_cs_n}, 16'h0000, "R10 chip select active");
        end
        strobe_n = 1'b1; load_n = 1'b1;
    endtask

    task automatic test_mid_reset;
        step(1'b1, 1'b1, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check(addr, 16'h0000, "R1 reset while counting");
        @(negedge clk); rst = 1'b0; cnt_en = 1'b0;
    endtask

    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; load_n = 1'b1; cnt_en = 1'b0; bus_in = 8'h00; strobe_n = 1'b1;
        test_reset();
        test_load_shift();
        test_load_with_enable();
        test_count_carry();
        test_hold();
        test_wrap();
        test_strobe();
        test_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule